// File: doc/BRIEF.md
# Return-Address Stack and Interrupt Vectoring Controller

This block owns a 10-bit program counter for a small processor core. Each cycle it either holds the counter, advances it by one, loads a branch target, performs a subroutine call, or returns from one. Return addresses live in a four-entry hidden stack that is not reachable through any port. Calls are the only way to write it and returns are the only way to read it.

Two interrupt sources are supported: an external request and a timer overflow. Each source has its own enable. A global interrupt mask bit lives inside the block. Acknowledging an interrupt clears this bit, and the interrupt-return strobe sets it again. A request is latched into a pending flag, so it is never lost.

An interrupt is acknowledged only when a stack slot is free. A pending request is simply held back while the stack is full. A plain call made on a full stack wraps around instead, and the oldest return address is overwritten.

Top module: `pcseq_ctrl`

## Requirements
- R1: After reset the counter reads 0x000, the acknowledge output is low, the stack is empty and the global mask bit is set (interrupts allowed).
- R2: A step strobe advances the counter by one, wrapping from 0x3FF to 0x000. A jump strobe loads the jump target.
- R3: A call loads the call target and pushes the counter value plus one. A return (plain or interrupt return) loads the most recently pushed address, so nested calls unwind in last-in, first-out order.
- R4: A call made while four addresses are stored overwrites the oldest one. Afterwards only the four most recent return addresses can be recovered, and the stack stays full.
- R5: A return with an empty stack loads 0x000 and leaves the stack empty.
- R6: An acknowledged external interrupt loads 0x004 and pushes the interrupted counter value. The acknowledge output is high for exactly the one cycle in which the counter first shows the vector. This happens two clock edges after a one-cycle request pulse.
- R7: An acknowledged timer interrupt loads 0x008 and otherwise behaves as in R6.
- R8: When both sources are pending and enabled, the external one is served first. The timer stays pending and is served after the interrupt return.
- R9: A request whose source enable is low stays pending without being acknowledged. It is served once the enable is raised.
- R10: While the stack is full, a pending enabled interrupt is not acknowledged and its flag stays set. Once a return frees a slot, it is served in the following cycle.
- R11: Acknowledgement clears the global mask bit, so no further interrupt is taken. An interrupt return pops the stack and sets the bit again.
- R12: Per cycle, return beats call, call beats jump, and jump beats step. An interrupt is taken only in a cycle without a call or return strobe. When taken, it overrides any jump or step in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance counter by one |
| jump_i | input | 1 | Load jump target |
| jump_tgt_i | input | 10 | Jump target address |
| call_i | input | 1 | Subroutine call strobe |
| call_tgt_i | input | 10 | Call target address |
| ret_i | input | 1 | Subroutine return strobe |
| reti_i | input | 1 | Interrupt return strobe (also sets the global mask bit) |
| ext_req_i | input | 1 | External interrupt request |
| ext_en_i | input | 1 | External interrupt enable |
| tmr_req_i | input | 1 | Timer overflow interrupt request |
| tmr_en_i | input | 1 | Timer interrupt enable |
| pc_o | output | 10 | Current program counter |
| ack_o | output | 1 | Interrupt acknowledge pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit address, a four-deep stack, and vectors at 0x004 and 0x008. With a stack this shallow, a sweep over every nesting depth from zero to six calls stays short. Each depth is followed by one return more than it pushed. This exercises the in-order unwind, the wrap that drops the oldest address, and the empty-stack return. The return addresses expected at each depth are computed from the call targets. The same small configuration lets the bench fill the stack completely before raising an interrupt, which reaches the deferred acknowledge.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_IRQ
  } pc_op_e;

  localparam int unsigned SRC_EXT = 0;
  localparam int unsigned SRC_TMR = 1;
  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/pcseq_irq_arb.sv
module pcseq_irq_arb #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            take_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] grant_o,
  output logic            any_o
);

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] grant;

  assign elig = pend_q & en_i;

  // fixed priority: lowest index wins
  always_comb begin
    grant = '0;
    for (int i = int'(NSRC) - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < int'(NSRC); g++) begin : g_flag
      always_comb begin
        pend_d[g] = pend_q[g];
        if (take_i && grant[g]) pend_d[g] = 1'b0;
        if (req_i[g])           pend_d[g] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q[g] <= 1'b0;
        end else if (pend_d[g] != pend_q[g]) begin
          pend_q[g] <= pend_d[g];
        end
      end

      // R9: an ungranted pending request is never dropped
      assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[g] && !(take_i && grant_o[g])) |=> pend_q[g]);
    end
  endgenerate

  assign pend_o  = pend_q;
  assign grant_o = grant;
  assign any_o   = |elig;

endmodule

// File: rtl/pcseq_rstack.sv
module pcseq_rstack #(
  parameter int unsigned AW    = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] top_o,
  output logic          full_o
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] rd_idx;
  logic [PW-1:0] wp_inc;
  logic          empty;
  logic          full;
  logic          do_pop;
  logic          do_push;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign rd_idx  = (wp_q == '0) ? LAST_IDX : wp_q - PW'(1);
  assign wp_inc  = (wp_q == LAST_IDX) ? '0 : wp_q + PW'(1);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && !pop_i;

  always_comb begin
    wp_d  = wp_q;
    cnt_d = cnt_q;
    if (do_pop) begin
      wp_d  = rd_idx;
      cnt_d = cnt_q - CW'(1);
    end else if (do_push) begin
      wp_d  = wp_inc;
      cnt_d = full ? cnt_q : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (do_pop || do_push) begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && (wp_q == PW'(g))) begin
          slot_q[g] <= push_addr_i;
        end
      end
    end
  endgenerate

  assign top_o  = empty ? '0 : slot_q[rd_idx];
  assign full_o = full;

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  assert_wrap_stays_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> full_o);

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty) |=> (empty && top_o == '0));

endmodule

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
#(
  parameter int unsigned AW      = 10,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned EXT_VEC = 'h004,
  parameter int unsigned TMR_VEC = 'h008
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          jump_i,
  input  logic [AW-1:0] jump_tgt_i,
  input  logic          call_i,
  input  logic [AW-1:0] call_tgt_i,
  input  logic          ret_i,
  input  logic          reti_i,
  input  logic          ext_req_i,
  input  logic          ext_en_i,
  input  logic          tmr_req_i,
  input  logic          tmr_en_i,
  output logic [AW-1:0] pc_o,
  output logic          ack_o
);

  localparam logic [AW-1:0] EXT_ADDR = AW'(EXT_VEC);
  localparam logic [AW-1:0] TMR_ADDR = AW'(TMR_VEC);

  logic [AW-1:0]      pc_q, pc_d;
  logic               gie_q, gie_d;
  logic               ack_q;
  pc_op_e             op;
  logic               any_ret;
  logic               take;
  logic               irq_any;
  logic [NUM_SRC-1:0] irq_req;
  logic [NUM_SRC-1:0] irq_en;
  logic [NUM_SRC-1:0] irq_pend;
  logic [NUM_SRC-1:0] irq_grant;
  logic               stk_push;
  logic               stk_pop;
  logic [AW-1:0]      stk_push_addr;
  logic [AW-1:0]      stk_top;
  logic               stk_full;
  logic [AW-1:0]      vec_addr;

  assign irq_req[SRC_EXT] = ext_req_i;
  assign irq_req[SRC_TMR] = tmr_req_i;
  assign irq_en[SRC_EXT]  = ext_en_i;
  assign irq_en[SRC_TMR]  = tmr_en_i;

  pcseq_irq_arb #(.NSRC(NUM_SRC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (irq_req),
    .en_i    (irq_en),
    .take_i  (take),
    .pend_o  (irq_pend),
    .grant_o (irq_grant),
    .any_o   (irq_any)
  );

  assign any_ret = ret_i || reti_i;
  assign take    = gie_q && irq_any && !stk_full && !call_i && !any_ret;

  // operation select, highest priority first
  always_comb begin
    if (any_ret)     op = OP_RET;
    else if (call_i) op = OP_CALL;
    else if (take)   op = OP_IRQ;
    else if (jump_i) op = OP_JUMP;
    else if (step_i) op = OP_STEP;
    else             op = OP_HOLD;
  end

  assign vec_addr      = irq_grant[SRC_EXT] ? EXT_ADDR : TMR_ADDR;
  assign stk_push      = (op == OP_CALL) || (op == OP_IRQ);
  assign stk_pop       = (op == OP_RET);
  assign stk_push_addr = (op == OP_CALL) ? pc_q + AW'(1) : pc_q;

  pcseq_rstack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (stk_push),
    .pop_i       (stk_pop),
    .push_addr_i (stk_push_addr),
    .top_o       (stk_top),
    .full_o      (stk_full)
  );

  always_comb begin
    unique case (op)
      OP_STEP: pc_d = pc_q + AW'(1);
      OP_JUMP: pc_d = jump_tgt_i;
      OP_CALL: pc_d = call_tgt_i;
      OP_RET:  pc_d = stk_top;
      OP_IRQ:  pc_d = vec_addr;
      default: pc_d = pc_q;
    endcase
  end

  always_comb begin
    gie_d = gie_q;
    if (take)        gie_d = 1'b0;
    else if (reti_i) gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (op != OP_HOLD) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b1;
      ack_q <= 1'b0;
    end else begin
      if (gie_d != gie_q) gie_q <= gie_d;
      ack_q <= take;
    end
  end

  assign pc_o  = pc_q;
  assign ack_o = ack_q;

  assert_ack_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (pc_q == EXT_ADDR || pc_q == TMR_ADDR));

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  assert_ack_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !gie_q);

  assert_ack_not_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !$past(stk_full));

  assert_defer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend[SRC_EXT] && stk_full && !any_ret) |=> irq_pend[SRC_EXT]);

endmodule

// File: tb/tb_pcseq_ctrl.sv
module tb_pcseq_ctrl;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_i, jump_i, call_i, ret_i, reti_i;
  logic [AW-1:0] jump_tgt_i, call_tgt_i;
  logic          ext_req_i, ext_en_i, tmr_req_i, tmr_en_i;
  logic [AW-1:0] pc_o;
  logic          ack_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pcseq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
    .jump_tgt_i(jump_tgt_i), .call_i(call_i), .call_tgt_i(call_tgt_i),
    .ret_i(ret_i), .reti_i(reti_i), .ext_req_i(ext_req_i), .ext_en_i(ext_en_i),
    .tmr_req_i(tmr_req_i), .tmr_en_i(tmr_en_i), .pc_o(pc_o), .ack_o(ack_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_pc(input string tag, input int exp);
    chk(int'(pc_o) == exp, tag, int'(pc_o), exp);
  endtask

  task automatic chk_ack(input string tag, input bit exp);
    chk(ack_o == exp, tag, int'(ack_o), int'(exp));
  endtask

  task automatic clear_in();
    step_i = 0; jump_i = 0; call_i = 0; ret_i = 0; reti_i = 0;
    ext_req_i = 0; tmr_req_i = 0; jump_tgt_i = '0; call_tgt_i = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    clear_in();
    ext_en_i = 1; tmr_en_i = 1;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic do_call(input int tgt);
    call_i = 1; call_tgt_i = AW'(tgt); tick();
  endtask

  task automatic do_ret();
    ret_i = 1; tick();
  endtask

  task automatic do_reti();
    reti_i = 1; tick();
  endtask

  task automatic do_step();
    step_i = 1; tick();
  endtask

  function automatic int tgt_of(input int k);
    return 'h40 * (k + 1) + k;
  endfunction

  function automatic int ret_of(input int k);
    return (k == 0) ? 1 : tgt_of(k - 1) + 1;
  endfunction

  initial begin
    int oldest;
    int exp;

    // R1 reset state
    do_reset();
    chk_pc("R1 reset pc", 0);
    chk_ack("R1 reset ack", 0);
    do_ret();
    chk_pc("R1 R5 empty after reset", 0);

    // R2 step, jump, wrap
    do_step(); do_step();
    chk_pc("R2 step", 2);
    jump_i = 1; jump_tgt_i = 'h3FF; tick();
    chk_pc("R2 jump", 'h3FF);
    do_step();
    chk_pc("R2 wrap", 0);

    // R3 R4 R5 sweep over nesting depth
    for (int n = 0; n <= 6; n++) begin
      do_reset();
      for (int k = 0; k < n; k++) begin
        do_call(tgt_of(k));
        chk_pc($sformatf("R3 call depth %0d", k + 1), tgt_of(k));
      end
      oldest = (n > 4) ? n - 4 : 0;
      for (int j = 0; j <= n; j++) begin
        int idx;
        idx = n - 1 - j;
        exp = (idx >= oldest) ? ret_of(idx) : 0;
        do_ret();
        if (idx >= oldest)
          chk_pc($sformatf("R3 R4 unwind n=%0d pop %0d", n, j), exp);
        else
          chk_pc($sformatf("R5 R4 empty pop n=%0d pop %0d", n, j), exp);
      end
    end

    // R6 R11 external interrupt
    do_reset();
    do_step(); do_step(); do_step();
    ext_req_i = 1; tick();
    chk_pc("R6 not yet taken", 3);
    chk_ack("R6 ack low while latching", 0);
    tick();
    chk_pc("R6 ext vector", 'h004);
    chk_ack("R6 ack pulse", 1);
    tmr_req_i = 1; tick();
    chk_ack("R6 ack one cycle", 0);
    tick(); tick();
    chk_pc("R11 masked after ack", 'h004);
    chk_ack("R11 no second ack", 0);
    do_reti();
    chk_pc("R11 reti returns", 3);
    tick();
    chk_pc("R7 R11 timer after reti", 'h008);
    chk_ack("R7 ack", 1);
    do_reti();
    chk_pc("R7 reti returns", 3);

    // R8 both at once
    do_reset();
    ext_req_i = 1; tmr_req_i = 1; tick();
    tick();
    chk_pc("R8 external first", 'h004);
    tick();
    chk_pc("R8 timer waits", 'h004);
    do_reti();
    chk_pc("R8 reti", 0);
    tick();
    chk_pc("R8 timer second", 'h008);

    // R9 enable gating
    do_reset();
    tmr_en_i = 0;
    tmr_req_i = 1; tick();
    tick(); tick();
    chk_pc("R9 disabled not taken", 0);
    chk_ack("R9 no ack", 0);
    tmr_en_i = 1;
    tick();
    chk_pc("R9 served after enable", 'h008);

    // R10 deferred while stack full
    do_reset();
    for (int k = 0; k < 4; k++) do_call(tgt_of(k));
    ext_req_i = 1; tick();
    tick(); tick();
    chk_pc("R10 held while full", tgt_of(3));
    chk_ack("R10 no ack while full", 0);
    do_ret();
    chk_pc("R10 ret frees slot", ret_of(3));
    tick();
    chk_pc("R10 served after ret", 'h004);
    chk_ack("R10 ack", 1);
    do_reti();
    chk_pc("R10 reti", ret_of(3));
    do_ret();
    chk_pc("R10 stack intact", ret_of(2));

    // R12 priorities
    do_reset();
    call_i = 1; call_tgt_i = 'h123; jump_i = 1; jump_tgt_i = 'h055; step_i = 1; tick();
    chk_pc("R12 call over jump/step", 'h123);
    ret_i = 1; call_i = 1; call_tgt_i = 'h200; tick();
    chk_pc("R12 ret over call", 1);
    jump_i = 1; jump_tgt_i = 'h0F0; step_i = 1; tick();
    chk_pc("R12 jump over step", 'h0F0);
    ext_req_i = 1; tick();
    jump_i = 1; jump_tgt_i = 'h111; tick();
    chk_pc("R12 irq over jump", 'h004);
    do_reti();
    chk_pc("R12 irq pushed current pc", 'h0F0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule